// File: doc/BRIEF.md
# Inverted Serial Radio-Control Frame Decoder

This block takes the single-wire serial output of a radio-control receiver, whose line levels are the inverse of a normal UART, and turns it into sixteen 11-bit proportional channel words, two on/off channels and two status flags. Inside it, a bit-level receiver samples each character at mid-bit and checks even parity and both stop bits. A frame assembler then collects 25 bytes, starting with a 0x0F start byte. A combinational unpacker pulls the channels and flags out of the stored bytes.

Outputs are held in registers. They change only on the cycle in which `valid_o` pulses, which is the cycle after a complete frame has been checked. Downstream logic can therefore read all channels as one consistent set. Pulse-width scaling and output pulse generation sit outside this block. The bit period is `CLK_HZ / BAUD_HZ` clocks; the defaults give 100 kbit/s.

Top module: `rcf_decoder`

## Requirements
- R1: `line_i` idles low. The decoder inverts it and receives characters as 1 start bit, 8 data bits least-significant first, 1 even-parity bit and 2 stop bits. Each bit lasts `CLK_HZ/BAUD_HZ` clocks.
- R2: While hunting, any well-formed byte other than 0x0F is discarded. A 0x0F byte starts a frame at index 0. After that, bytes are stored in order up to index 24, including data bytes equal to 0x0F.
- R3: If the byte at index 24 is not 0x00, the frame is dropped. `valid_o` stays low, the outputs keep their previous values, and hunting resumes.
- R4: A character whose parity bit makes the count of ones over data and parity odd aborts the current frame and returns the decoder to hunting.
- R5: A character with either stop bit sampled as a space (line_i high) aborts the current frame and returns the decoder to hunting.
- R6: Data bytes 1..22 form a 176-bit little-endian vector, byte 1 in bits 7:0. Channel k (k = 0..15) is bits 11k+10..11k of that vector and drives `ch_o[11k+10:11k]`.
- R7: From the flag byte at index 23: bit 7 drives `dig_o[0]`, bit 6 drives `dig_o[1]`, bit 5 drives `lost_o` and bit 4 drives `fs_o`. Bits 3..0 are ignored.
- R8: `valid_o` is high for exactly one cycle per accepted frame. All data outputs change only in that cycle.
- R9: After reset, all outputs are 0.
- R10: A high pulse on `line_i` shorter than half a bit period is not taken as a start bit.
- R11: After an abort, a frame that follows immediately is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Inverted serial line, idle low |
| ch_o | output | 176 | Sixteen 11-bit channels, channel k at bits 11k+10:11k |
| dig_o | output | 2 | Digital channels: bit 0 from flag bit 7, bit 1 from flag bit 6 |
| lost_o | output | 1 | Frame-lost flag from the last accepted frame |
| fs_o | output | 1 | Failsafe flag from the last accepted frame |
| valid_o | output | 1 | One-cycle strobe when a frame is accepted |

## Verification
The assertions assume that frames are separated by many clock cycles. This means two `valid_o` pulses can never fall on adjacent cycles. They also assume `line_i` changes no faster than the sampling counter can follow. The stimulus drives every bit for a whole bit period, on the falling clock edge. Corrupted characters, bad end bytes, leading junk and a short glitch are always followed by idle time or by a complete well-formed frame, so the receiver is never given a stream that is ambiguous by design.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int FRAME_BYTES = 25;
  localparam int DATA_BYTES  = 22;
  localparam int NUM_CH      = 16;
  localparam int CH_W        = 11;
  localparam int FLAG_IDX    = 23;
  localparam int END_IDX     = 24;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam logic [7:0] START_BYTE = 8'h0F;
  localparam logic [7:0] END_BYTE   = 8'h00;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP1, RX_STOP2
  } rx_state_e;
endpackage

// File: rtl/rcf_rx_bit.sv
module rcf_rx_bit #(
  parameter int CLKS_PER_BIT = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       vld_o,
  output logic       err_o,
  output logic [7:0] byte_o
);
  import rcf_pkg::*;
  localparam int CNT_W = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);

  logic [1:0]       sync_q;
  logic             rxd;
  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             perr_q, serr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], line_i};
  end
  assign rxd = ~sync_q[1];  // restore UART polarity

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      perr_q <= 1'b0;
      serr_q <= 1'b0;
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (!rxd) begin
          st_q  <= RX_START;
          cnt_q <= HALF;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= FULL;
        unique case (st_q)
          RX_START: begin
            if (!rxd) begin
              st_q   <= RX_DATA;
              bit_q  <= '0;
              perr_q <= 1'b0;
              serr_q <= 1'b0;
            end else begin
              st_q <= RX_IDLE;  // glitch
            end
          end
          RX_DATA: begin
            sh_q  <= {rxd, sh_q[7:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) st_q <= RX_PAR;
          end
          RX_PAR: begin
            perr_q <= ^sh_q ^ rxd;
            st_q   <= RX_STOP1;
          end
          RX_STOP1: begin
            serr_q <= ~rxd;
            st_q   <= RX_STOP2;
          end
          RX_STOP2: begin
            vld_o <= 1'b1;
            err_o <= perr_q | serr_q | ~rxd;
            st_q  <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/rcf_frame_asm.sv
module rcf_frame_asm
  import rcf_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic                    err_i,
  input  logic [7:0]              byte_i,
  output logic [DATA_BYTES*8-1:0] payload_o,
  output logic [7:0]              flags_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    frame_ok_o
);
  logic [7:0]       buf_q [FRAME_BYTES];
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < FRAME_BYTES; i++) buf_q[i] <= '0;
    end else if (vld_i) begin
      if (err_i) begin
        idx_q <= '0;
      end else if (idx_q == '0) begin
        if (byte_i == START_BYTE) begin
          buf_q[0] <= byte_i;
          idx_q    <= IDX_W'(1);
        end
      end else begin
        buf_q[idx_q] <= byte_i;
        idx_q <= (idx_q == IDX_W'(END_IDX)) ? '0 : idx_q + 1'b1;
      end
    end
  end

  for (genvar j = 0; j < DATA_BYTES; j++) begin : g_pl
    assign payload_o[j*8 +: 8] = buf_q[j+1];
  end

  assign flags_o    = buf_q[FLAG_IDX];
  assign idx_o      = idx_q;
  assign frame_ok_o = vld_i && !err_i && (idx_q == IDX_W'(END_IDX)) &&
                      (byte_i == END_BYTE) && (buf_q[0] == START_BYTE);
endmodule

// File: rtl/rcf_unpack.sv
module rcf_unpack
  import rcf_pkg::*;
(
  input  logic [DATA_BYTES*8-1:0] payload_i,
  input  logic [7:0]              flags_i,
  output logic [NUM_CH*CH_W-1:0]  ch_o,
  output logic [1:0]              dig_o,
  output logic                    lost_o,
  output logic                    fs_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_o[k*CH_W +: CH_W] = payload_i[k*CH_W +: CH_W];
  end
  assign dig_o  = {flags_i[6], flags_i[7]};
  assign lost_o = flags_i[5];
  assign fs_o   = flags_i[4];
endmodule

// File: rtl/rcf_decoder.sv
module rcf_decoder
  import rcf_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BAUD_HZ = 100_000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   line_i,
  output logic [NUM_CH*CH_W-1:0] ch_o,
  output logic [1:0]             dig_o,
  output logic                   lost_o,
  output logic                   fs_o,
  output logic                   valid_o
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD_HZ;

  logic                    rx_vld, rx_err;
  logic [7:0]              rx_byte;
  logic [DATA_BYTES*8-1:0] payload;
  logic [7:0]              flags;
  logic [IDX_W-1:0]        asm_idx;
  logic                    frame_ok;
  logic [NUM_CH*CH_W-1:0]  ch_d;
  logic [1:0]              dig_d;
  logic                    lost_d, fs_d;

  rcf_rx_bit #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i, .rst_ni, .line_i,
    .vld_o(rx_vld), .err_o(rx_err), .byte_o(rx_byte)
  );

  rcf_frame_asm u_asm (
    .clk_i, .rst_ni,
    .vld_i(rx_vld), .err_i(rx_err), .byte_i(rx_byte),
    .payload_o(payload), .flags_o(flags), .idx_o(asm_idx),
    .frame_ok_o(frame_ok)
  );

  rcf_unpack u_unp (
    .payload_i(payload), .flags_i(flags),
    .ch_o(ch_d), .dig_o(dig_d), .lost_o(lost_d), .fs_o(fs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_o    <= '0;
      dig_o   <= '0;
      lost_o  <= 1'b0;
      fs_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= frame_ok;
      if (frame_ok) begin
        ch_o   <= ch_d;
        dig_o  <= dig_d;
        lost_o <= lost_d;
        fs_o   <= fs_d;
      end
    end
  end
endmodule

// File: rtl/rcf_decoder_chk.sv
module rcf_decoder_chk
  import rcf_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_o,
  input logic [NUM_CH*CH_W-1:0] ch_o,
  input logic [1:0]             dig_o,
  input logic                   lost_o,
  input logic                   fs_o,
  input logic                   rx_vld,
  input logic                   rx_err,
  input logic [7:0]             rx_byte,
  input logic [IDX_W-1:0]       asm_idx
);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(ch_o) && $stable(dig_o) && $stable(lost_o) && $stable(fs_o));

  a_r3_bad_end_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld && asm_idx == IDX_W'(END_IDX) && rx_byte != END_BYTE |=> !valid_o && asm_idx == '0);

  a_r4_err_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld && rx_err |=> !valid_o && asm_idx == '0);

  a_r2_hunt_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld && asm_idx == '0 && rx_byte != START_BYTE |=> asm_idx == '0);

  a_r2_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asm_idx <= IDX_W'(END_IDX));
endmodule

bind rcf_decoder rcf_decoder_chk u_chk (
  .clk_i, .rst_ni, .valid_o, .ch_o, .dig_o, .lost_o, .fs_o,
  .rx_vld, .rx_err, .rx_byte, .asm_idx
);

// File: tb/rcf_decoder_tb.sv
`timescale 1ns/1ps
module rcf_decoder_tb;
  localparam int CPB = 16;
  localparam int NCH = 16;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0;
  logic [NCH*11-1:0] ch;
  logic [1:0] dig;
  logic lost, fs, valid;

  always #2.5 clk = ~clk;

  rcf_decoder #(.CLK_HZ(CPB*100_000), .BAUD_HZ(100_000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .ch_o(ch), .dig_o(dig), .lost_o(lost), .fs_o(fs), .valid_o(valid)
  );

  int checks = 0, errors = 0, vcount = 0;
  logic [7:0]  fb [25];
  logic [175:0] exp_pl = '0;
  logic [7:0]  exp_fl = '0;

  // kind[23:20] seed[19:8] flags[7:0]
  // kind: 0 good, 1 bad end, 2 parity err, 3 stop err, 4 junk then good, 5 parity err then good
  localparam logic [23:0] VEC [9] = '{
    {4'd0, 12'h123, 8'h00}, {4'd0, 12'h000, 8'hFF}, {4'd0, 12'hFFF, 8'h80},
    {4'd0, 12'h00F, 8'h40}, {4'd1, 12'h2A5, 8'h30}, {4'd2, 12'h3C1, 8'h00},
    {4'd3, 12'h1B7, 8'h20}, {4'd4, 12'h777, 8'h10}, {4'd5, 12'h456, 8'hC0}
  };

  always @(negedge clk) if (rst_n && valid) vcount++;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    line = ~b;  // R1: inverted line
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, bit bad_par = 0, bit bad_stop = 0);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(^b ^ bad_par);
    send_bit(!bad_stop);
    send_bit(1'b1);
  endtask

  task automatic idle_bytes(int n);
    line = 1'b0;
    repeat (n*12*CPB) @(negedge clk);
  endtask

  task automatic build(logic [11:0] seed, logic [7:0] flags, logic [7:0] endb);
    fb[0] = 8'h0F;
    for (int j = 1; j <= 22; j++) begin
      if (seed == 12'h000)      fb[j] = 8'h00;
      else if (seed == 12'hFFF) fb[j] = 8'hFF;
      else if (seed == 12'h00F) fb[j] = 8'h0F;
      else fb[j] = 8'((seed * 7 + j * 29) ^ (j << 3));
    end
    fb[23] = flags;
    fb[24] = endb;
  endtask

  task automatic send_frame(int err_at = -1, bit par = 0);
    for (int j = 0; j < 25; j++) begin
      if (j == err_at) begin
        send_byte(fb[j], par, !par);
        return;
      end
      send_byte(fb[j]);
    end
  endtask

  task automatic accept_expected();
    for (int j = 0; j < 22; j++) exp_pl[j*8 +: 8] = fb[j+1];
    exp_fl = fb[23];
  endtask

  task automatic check_outs(string req);
    for (int k = 0; k < NCH; k++)
      chk(ch[k*11 +: 11] == exp_pl[k*11 +: 11], req, $sformatf("R6 ch%0d", k),
          32'(ch[k*11 +: 11]), 32'(exp_pl[k*11 +: 11]));
    chk(dig == {exp_fl[6], exp_fl[7]}, req, "R7 dig", 32'(dig), 32'({exp_fl[6], exp_fl[7]}));
    chk(lost == exp_fl[5], req, "R7 lost", 32'(lost), 32'(exp_fl[5]));
    chk(fs == exp_fl[4], req, "R7 fs", 32'(fs), 32'(exp_fl[4]));
  endtask

  task automatic good_frame(string req);
    int v0;
    v0 = vcount;
    send_frame();
    idle_bytes(1);
    accept_expected();
    chk(vcount == v0 + 1, req, "R8 valid pulses", 32'(vcount - v0), 32'd1);
    check_outs(req);
  endtask

  initial begin
    #(150_000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(ch == '0, "R9", "ch", 32'(ch[31:0]), 0);
    chk({dig, lost, fs, valid} == '0, "R9", "flags", 32'({dig, lost, fs, valid}), 0);
    idle_bytes(1);

    foreach (VEC[n]) begin
      logic [3:0] kind;
      int v0;
      kind = VEC[n][23:20];
      v0 = vcount;
      case (kind)
        4'd0: begin build(VEC[n][19:8], VEC[n][7:0], 8'h00); good_frame("R1/R2/R6"); end
        4'd1: begin
          build(VEC[n][19:8], VEC[n][7:0], 8'h04);
          send_frame(); idle_bytes(1);
          chk(vcount == v0, "R3", "valid on bad end", 32'(vcount - v0), 0);
          check_outs("R3");
        end
        4'd2, 4'd3: begin
          build(VEC[n][19:8], VEC[n][7:0], 8'h00);
          send_frame(kind == 4'd2 ? 10 : 5, kind == 4'd2);
          idle_bytes(2);
          chk(vcount == v0, kind == 4'd2 ? "R4" : "R5", "valid after error",
              32'(vcount - v0), 0);
          check_outs(kind == 4'd2 ? "R4" : "R5");
        end
        4'd4: begin
          send_byte(8'h55); send_byte(8'hF0); send_byte(8'h00);
          build(VEC[n][19:8], VEC[n][7:0], 8'h00);
          good_frame("R2 junk");
        end
        default: begin
          build(VEC[n][19:8], VEC[n][7:0], 8'h00);
          send_frame(3, 1'b1);
          good_frame("R11");
        end
      endcase
    end

    // R10: short glitch
    begin
      int v0;
      v0 = vcount;
      line = 1'b1;
      repeat (3) @(negedge clk);
      line = 1'b0;
      idle_bytes(2);
      chk(vcount == v0, "R10", "glitch produced frame", 32'(vcount - v0), 0);
      check_outs("R10");
      build(12'h2B9, 8'h90, 8'h00);
      good_frame("R10 after glitch");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule